// File: doc/BRIEF.md
# External Bus Request Arbiter

This block decides who drives a processor's external memory bus: the core or an outside master. The outside master raises a bus request. Once the request has crossed into the local clock domain and the bus is free, the block floats the address, data and strobe drivers. In the same cycle it raises the grant and stalls the core. If the core has an external access in flight, the hand-over waits until that access has finished. The wait is bounded by the access, not by the instruction that issued it, so the grant can fall between two accesses made by the same instruction.

A mode input selects how the core behaves while the bus is lent out. In halt mode the core stops for the whole grant. In run-on mode the core keeps executing and is held only in the cycles where it asks for the external bus. When the request is withdrawn, the drivers come back and the grant drops first. The stall follows one cycle later, so the core never issues an access onto a bus that is still changing hands.

Top module: `ext_bus_arbiter`

## Requirements
- R1: While reset is high and in the first cycle after it, bus_hiz_o, bus_grant_o and core_stall_o are all 0.
- R2: bus_req_i passes through two synchroniser flops before use. With the bus idle, grant appears in the third cycle after the first cycle in which the request is high.
- R3: Grant is never raised in the cycle after a cycle with core_xbusy_i high. When a request is held during a busy access, grant appears in the cycle after the first non-busy cycle.
- R4: bus_hiz_o is 1 exactly in the cycles where bus_grant_o is 1.
- R5: With run_on_i = 0, core_stall_o is 1 in every cycle with grant.
- R6: With run_on_i = 1 and grant active, core_stall_o equals core_xreq_i.
- R7: After the synchronised request falls, grant and hiz drop one cycle later. The stall rule of R5/R6 then still holds for exactly one more cycle, after which core_stall_o returns to 0.
- R8: In a cycle where the core is idle, the synchronised request is high and core_xbusy_i is 0, a core_xreq_i of 1 gives core_stall_o = 1. A new access therefore cannot start in the cycle that leads into the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req_i | input | 1 | Bus request from the outside master, asynchronous |
| core_xreq_i | input | 1 | Core wants to start an external access this cycle |
| core_xbusy_i | input | 1 | An external core access is in progress |
| run_on_i | input | 1 | 1 = core keeps running during grant and stalls only on external accesses |
| bus_hiz_o | output | 1 | Floats address, data and strobe drivers |
| bus_grant_o | output | 1 | Bus grant to the outside master |
| core_stall_o | output | 1 | Holds the core |

## Verification
The assertions check several rules on every cycle:
- hiz and grant always agree.
- Grant never begins right after a busy cycle and always follows a high synchronised request.
- In halt mode the core is held for the whole grant.
- A core request during grant is always stalled.

Only the bench scenarios can show the exact latencies:
- the three-cycle path through the synchroniser,
- the deferral of grant to the cycle after the first free cycle,
- the one-cycle gap between the drivers returning and the stall releasing.

The same scenarios cover the collision where the core requests in the cycle in which grant is decided, and a reset taken mid-grant.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ARB_CORE    = 2'd0,
    ARB_LENT    = 2'd1,
    ARB_RETURN  = 2'd2
  } arb_state_t;
endpackage

// File: rtl/arb_req_sync.sv
module arb_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= 1'b0;
    else     chain_q[0] <= async_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[i] <= 1'b0;
      else     chain_q[i] <= chain_q[i-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/arb_grant_fsm.sv
module arb_grant_fsm
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_s_i,
  input  logic       xbusy_i,
  output arb_state_t state_o,
  output logic       grant_o,
  output logic       hiz_o
);
  arb_state_t state_q, state_d;
  logic       grant_q, hiz_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ARB_CORE:   if (req_s_i && !xbusy_i) state_d = ARB_LENT;
      ARB_LENT:   if (!req_s_i)            state_d = ARB_RETURN;
      ARB_RETURN:                          state_d = ARB_CORE;
      default:                             state_d = ARB_CORE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ARB_CORE;
      grant_q <= 1'b0;
      hiz_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      grant_q <= (state_d == ARB_LENT);
      hiz_q   <= (state_d == ARB_LENT);
    end
  end

  assign state_o = state_q;
  assign grant_o = grant_q;
  assign hiz_o   = hiz_q;

  p_grant_after_free_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_q) |-> $past(!xbusy_i));
  p_grant_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_q) |-> $past(req_s_i));
  p_release_order_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(grant_q) |-> state_q == ARB_RETURN);
endmodule

// File: rtl/arb_stall_ctrl.sv
module arb_stall_ctrl
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  arb_state_t state_i,
  input  logic       req_s_i,
  input  logic       xreq_i,
  input  logic       xbusy_i,
  input  logic       run_on_i,
  output logic       stall_o
);
  logic lent_or_return;
  logic collide;

  assign lent_or_return = (state_i == ARB_LENT) || (state_i == ARB_RETURN);
  assign collide        = (state_i == ARB_CORE) && req_s_i && !xbusy_i && xreq_i;

  always_comb begin
    stall_o = 1'b0;
    if (lent_or_return) stall_o = !run_on_i || xreq_i;
    else if (collide)   stall_o = 1'b1;
  end

  p_core_xreq_held_r8: assert property (@(posedge clk) disable iff (rst)
    (state_i == ARB_CORE && req_s_i && !xbusy_i && xreq_i) |-> stall_o);
endmodule

// File: rtl/ext_bus_arbiter.sv
module ext_bus_arbiter
  import arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_req_i,
  input  logic core_xreq_i,
  input  logic core_xbusy_i,
  input  logic run_on_i,
  output logic bus_hiz_o,
  output logic bus_grant_o,
  output logic core_stall_o
);
  logic       req_s;
  arb_state_t state;

  arb_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (bus_req_i),
    .sync_o  (req_s)
  );

  arb_grant_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .req_s_i (req_s),
    .xbusy_i (core_xbusy_i),
    .state_o (state),
    .grant_o (bus_grant_o),
    .hiz_o   (bus_hiz_o)
  );

  arb_stall_ctrl u_stall (
    .clk      (clk),
    .rst      (rst),
    .state_i  (state),
    .req_s_i  (req_s),
    .xreq_i   (core_xreq_i),
    .xbusy_i  (core_xbusy_i),
    .run_on_i (run_on_i),
    .stall_o  (core_stall_o)
  );

  p_hiz_tracks_grant_r4: assert property (@(posedge clk) disable iff (rst)
    bus_hiz_o == bus_grant_o);
  p_halt_stalls_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_grant_o && !run_on_i) |-> core_stall_o);
  p_runon_xreq_stalls_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_grant_o && core_xreq_i) |-> core_stall_o);
  p_stall_after_drop_r7: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_grant_o) && !run_on_i) |-> core_stall_o);
endmodule

// File: tb/test_ext_bus_arbiter.sv
module test_ext_bus_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 42;
  // {req, xreq, busy, run_on, exp_grant(=hiz), exp_stall}
  localparam logic [5:0] VEC [NVEC] = '{
    6'b0000_00, 6'b1000_00, 6'b1000_00, 6'b1000_00, 6'b1000_11, // 0-4  R2
    6'b0000_11, 6'b0000_11, 6'b0000_11, 6'b0000_01, 6'b0000_00, // 5-9  R5 R7
    6'b1010_00, 6'b1010_00, 6'b1010_00, 6'b1010_00, 6'b1000_00, // 10-14 R3
    6'b1000_11, 6'b0000_11, 6'b0000_11, 6'b0000_11, 6'b0000_01, // 15-19
    6'b0000_00, 6'b1001_00, 6'b1001_00, 6'b1001_00, 6'b1001_10, // 20-24 R6
    6'b1101_11, 6'b1001_10, 6'b0101_11, 6'b0101_11, 6'b0101_11, // 25-29
    6'b0101_01, 6'b0101_00, 6'b0001_00, 6'b1000_00, 6'b1000_00, // 30-34
    6'b1100_01, 6'b1100_11, 6'b0100_11, 6'b0100_11, 6'b0100_11, // 35-39 R8
    6'b0100_01, 6'b0100_00                                      // 40-41
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_req_i = 1'b0, core_xreq_i = 1'b0, core_xbusy_i = 1'b0, run_on_i = 1'b0;
  logic bus_hiz_o, bus_grant_o, core_stall_o;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_bus_arbiter i_ext_bus_arbiter (
    .clk(clk), .rst(rst), .bus_req_i(bus_req_i), .core_xreq_i(core_xreq_i),
    .core_xbusy_i(core_xbusy_i), .run_on_i(run_on_i),
    .bus_hiz_o(bus_hiz_o), .bus_grant_o(bus_grant_o), .core_stall_o(core_stall_o)
  );

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: {hiz,grant,stall} got %b expected %b", req, $time, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 reset", {bus_hiz_o, bus_grant_o, core_stall_o}, 3'b000);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < NVEC; k++) begin
      if (k > 0) @(negedge clk);
      {bus_req_i, core_xreq_i, core_xbusy_i, run_on_i} = VEC[k][5:2];
      #1;
      // vector table covers R2 R3 R4 R5 R6 R7 R8
      check($sformatf("R2-table vector %0d", k), {bus_hiz_o, bus_grant_o, core_stall_o},
            {VEC[k][1], VEC[k][1], VEC[k][0]});
    end
    // R1: reset taken during a grant clears all outputs
    @(negedge clk);
    {bus_req_i, core_xreq_i, core_xbusy_i, run_on_i} = 4'b1000;
    repeat (4) @(negedge clk);
    #1 check("R4 grant before reset", {bus_hiz_o, bus_grant_o, core_stall_o}, 3'b111);
    @(negedge clk);
    rst = 1'b1;
    bus_req_i = 1'b0;
    @(posedge clk);
    #1 check("R1 reset mid-grant", {bus_hiz_o, bus_grant_o, core_stall_o}, 3'b000);
    @(negedge clk);
    rst = 1'b0;
    #1 check("R1 first cycle after reset", {bus_hiz_o, bus_grant_o, core_stall_o}, 3'b000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule